// File: doc/BRIEF.md
# Split Condition-Flag Rename Tracker

This block sits in the rename stage of an out-of-order core and keeps track of which in-flight reorder-buffer entry will produce the newest value of each condition-flag group. The flag word is divided into three groups that are renamed independently: carry, status (negative, zero, overflow) and configuration. A chain of carry-only updates therefore never waits on the status flags, and the reverse also holds.

Each renamed instruction states which groups it reads, which groups it writes, and which of its written groups it updates only partially. For every group it needs, the tracker returns an implicit source tag and a ready bit. It also returns the operand bits, taken from the committed flags or from per-entry flag storage. Writeback fills that storage. In-order commit merges the written groups into the committed flag word. A flush discards all in-flight work. A save/restore port exposes the committed groups as one word and reloads all three groups at once.

Top module: `flag_rename_tracker`

## Requirements
- R1: After reset the reorder buffer is empty, the allocation tag is 0, no group has an in-flight producer, the committed flag word is 0 and rename is not stalled while all inputs are low.
- R2: An accepted rename takes the entry given on ren_tag. Entries are handed out in ascending order and wrap after the last one. ren_stall is raised while all entries are occupied.
- R3: Group index 0 is carry, 1 is status and 2 is configuration. When an instruction needs a group, src_busy for that group shows whether an in-flight producer exists and src_tag names the newest one. Writing one group leaves the mappings of the other groups unchanged.
- R4: A group is needed when its bit in ren_rd is set, or when its bits in both ren_wr and ren_part are set (a partial update serialises on the previous producer). For a group that is not needed, src_busy is 0, src_ready is 1, its src_tag slot is 0 and its src_flags bits are 0.
- R5: src_ready for a needed group is 1 when the group has no in-flight producer, when the producer has written back, or when a writeback to that producer's tag arrives in the same cycle. A writeback is stored only for an occupied entry that has not yet written back; other writebacks have no effect.
- R6: The src_flags bits of a needed group come from the committed word when the group has no producer. Otherwise they come from the producer's stored flags once it has written back, or else from wb_flags on a same-cycle writeback, and are 0 in any other case. The bit layout is carry at bit 0, negative/zero/overflow at bits 1/2/3, and configuration at bit 4 and above.
- R7: When cmt_valid is high and the oldest entry has written back, that entry retires and cmt_done pulses. The groups it wrote are copied from its stored flags into the committed word, and its other groups are kept. Otherwise nothing retires.
- R8: When a group's producer retires and no newer writer of that group is renamed in the same cycle, the group has no in-flight producer afterwards.
- R9: A configuration writer is stalled until the reorder buffer is empty. While a configuration writer is in flight, every rename is stalled.
- R10: A flush empties the reorder buffer, discards every stored result, clears all group mappings and leaves the committed word unchanged. In that cycle, rename, writeback, commit and restore have no effect.
- R11: A restore loads restore_word into all three groups at once when the reorder buffer is empty and no flush is present, and is ignored otherwise. Rename is stalled in any cycle with restore_valid. arch_flags always shows the committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | Instruction offered for rename |
| ren_rd | input | 3 | Groups read (bit per group) |
| ren_wr | input | 3 | Groups written |
| ren_part | input | 3 | Written groups updated only partially |
| ren_stall | output | 1 | Rename cannot accept this cycle |
| ren_tag | output | TAG_W | Entry allocated to the renamed instruction |
| src_busy | output | 3 | Needed group has an in-flight producer |
| src_ready | output | 3 | Needed group value available |
| src_tag | output | 3*TAG_W | Producer tag per group, group g at bits g*TAG_W |
| src_flags | output | FLAG_W | Operand flag bits for needed groups |
| wb_valid | input | 1 | Flag result written back |
| wb_tag | input | TAG_W | Entry being written back |
| wb_flags | input | FLAG_W | Flag value produced by that entry |
| cmt_valid | input | 1 | Retire the oldest entry if it is done |
| cmt_done | output | 1 | Oldest entry retired this cycle |
| flush | input | 1 | Squash all in-flight entries |
| restore_valid | input | 1 | Load the committed word |
| restore_word | input | FLAG_W | Word to restore |
| arch_flags | output | FLAG_W | Committed flag word (save path) |

## Verification
A scripted opening builds a dependency chain. A carry-and-status writer is followed by a carry reader, a carry-only writer, a two-group reader that meets a same-cycle writeback, and a partial status update. Together these separate per-group mappings from a single shared mapping and show the wakeup bypass. A long random phase follows and mixes renames, including rare configuration writers, with writebacks to pending, finished and empty entries. It also mixes retire requests, flushes and restores, which exercises the stall rules, ignored writebacks, mapping release at retirement, and restores that arrive with or without entries in flight. A behavioural reference model in the bench predicts every output on every cycle.

// File: rtl/flagren_pkg.sv
// Shared constants for the split flag-group rename tracker.
// Assumes the flag word layout: carry at bit 0, status at bits 3:1,
// configuration from bit 4 upward.
package flagren_pkg;
    localparam int unsigned NGRP      = 3;
    localparam int unsigned GRP_CARRY = 0;
    localparam int unsigned GRP_STAT  = 1;
    localparam int unsigned GRP_CFG   = 2;
    localparam int unsigned STAT_W    = 3;

    // Maps a flag-word bit position to the group that owns it.
    function automatic int unsigned grp_of_bit(input int unsigned b);
        if (b == 0)
            return GRP_CARRY;
        else if (b <= STAT_W)
            return GRP_STAT;
        else
            return GRP_CFG;
    endfunction
endpackage

// File: rtl/fr_rob_store.sv
// Per-entry flag storage and in-order pointers of the reorder buffer.
// Holds occupancy, done bit, write mask and produced flags per entry.
// Assumes the caller allocates only when not full and retires only a
// done head entry; flush empties everything.
module fr_rob_store #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned FLAG_W = 8,
    parameter int unsigned NGRP   = 3,
    parameter int unsigned CFG_G  = 2,
    localparam int unsigned TAG_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [NGRP-1:0]   alloc_wmask,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [FLAG_W-1:0] wb_flags,
    input  logic              retire,
    input  logic              flush,
    output logic [TAG_W-1:0]  head,
    output logic [TAG_W-1:0]  tail,
    output logic [CNT_W-1:0]  count,
    output logic [DEPTH-1:0]  done_vec,
    output logic [FLAG_W-1:0] ent_flags [DEPTH],
    output logic              head_occ,
    output logic              head_done,
    output logic [NGRP-1:0]   head_wmask,
    output logic              cfg_inflight
);
    logic [DEPTH-1:0] occ;
    logic [NGRP-1:0]  wmask [DEPTH];
    logic             wb_take;

    // Wrap-around successor of a pointer.
    function automatic logic [TAG_W-1:0] nxt(input logic [TAG_W-1:0] p);
        return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Writeback is accepted only for a live entry still waiting.
    assign wb_take    = wb_valid && occ[wb_tag] && !done_vec[wb_tag];
    assign head_occ   = occ[head];
    assign head_done  = done_vec[head];
    assign head_wmask = wmask[head];

    // Detects any occupied entry that writes the configuration group.
    always_comb begin
        cfg_inflight = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (occ[i] && wmask[i][CFG_G]) cfg_inflight = 1'b1;
    end

    // Pointer and count update for allocate, retire and flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (flush) begin
            tail  <= head;
            count <= '0;
        end else begin
            if (retire) head <= nxt(head);
            if (alloc)  tail <= nxt(tail);
            count <= count + CNT_W'(alloc) - CNT_W'(retire);
        end
    end

    // Per-entry state: occupancy, completion, mask and stored flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ      <= '0;
            done_vec <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                wmask[i]     <= '0;
                ent_flags[i] <= '0;
            end
        end else if (flush) begin
            occ      <= '0;
            done_vec <= '0;
        end else begin
            if (wb_take) begin
                done_vec[wb_tag]  <= 1'b1;
                ent_flags[wb_tag] <= wb_flags;
            end
            if (retire) begin
                occ[head]      <= 1'b0;
                done_vec[head] <= 1'b0;
            end
            if (alloc) begin
                occ[tail]      <= 1'b1;
                done_vec[tail] <= 1'b0;
                wmask[tail]    <= alloc_wmask;
            end
        end
    end

    // R2: occupancy bits always agree with the entry count.
    a_r2_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(occ) == int'(count));
    // R2: the count never exceeds the depth.
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R7: a retire only ever hits an occupied, finished head.
    a_r7_retire_done: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (occ[head] && done_vec[head]));
    // R10: after a flush the buffer is empty.
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && occ == '0));
endmodule

// File: rtl/fr_group_map.sv
// Rename mapping of one flag group: a valid bit and the tag of the
// newest in-flight producer. Assumes retire_tag is the head entry and
// that a same-cycle writer of the group wins over a release.
module fr_group_map #(
    parameter int unsigned TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_group,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             retire,
    input  logic [TAG_W-1:0] retire_tag,
    input  logic             flush,
    output logic             map_valid,
    output logic [TAG_W-1:0] map_tag
);
    // Mapping update: claim on write, release on producer retire.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            map_valid <= 1'b0;
            map_tag   <= '0;
        end else if (wr_group) begin
            map_valid <= 1'b1;
            map_tag   <= alloc_tag;
        end else if (retire && map_valid && map_tag == retire_tag) begin
            map_valid <= 1'b0;
        end
    end

    // R3: a writer of this group becomes its producer next cycle.
    a_r3_map_follows_writer: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_group && !flush) |=> (map_valid && map_tag == $past(alloc_tag)));
    // R8: retiring the producer with no newer writer releases the group.
    a_r8_release_on_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && map_valid && map_tag == retire_tag && !wr_group) |=> !map_valid);
    // R10: flush leaves no producer mapped.
    a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !map_valid);
endmodule

// File: rtl/fr_arch_flags.sv
// Committed flag word. Commit merges the written groups bit by bit,
// restore replaces the whole word. Assumes the two never coincide.
module fr_arch_flags #(
    parameter int unsigned FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [FLAG_W-1:0] commit_mask,
    input  logic [FLAG_W-1:0] commit_flags,
    input  logic              restore,
    input  logic [FLAG_W-1:0] restore_word,
    output logic [FLAG_W-1:0] arch
);
    // Committed word update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            arch <= '0;
        else if (restore)
            arch <= restore_word;
        else if (commit)
            arch <= (arch & ~commit_mask) | (commit_flags & commit_mask);
    end

    // R11: a restore lands in all groups next cycle.
    a_r11_restore_loads: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> arch == $past(restore_word));
    // R10: without commit or restore the committed word holds.
    a_r10_arch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !restore) |=> $stable(arch));
    // R11: restore and commit are never requested together.
    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && restore));
endmodule

// File: rtl/flag_rename_tracker.sv
// Split flag-group rename tracker. Carry, status and configuration
// groups each have their own producer mapping. Readers get one implicit
// source per needed group with a same-cycle writeback bypass.
// Assumes one rename, one writeback and one retire per cycle at most.
module flag_rename_tracker
    import flagren_pkg::*;
#(
    parameter int unsigned ROB_DEPTH = 16,
    parameter int unsigned CFG_W     = 4,
    localparam int unsigned TAG_W  = $clog2(ROB_DEPTH),
    localparam int unsigned FLAG_W = 1 + STAT_W + CFG_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ren_valid,
    input  logic [2:0]              ren_rd,
    input  logic [2:0]              ren_wr,
    input  logic [2:0]              ren_part,
    output logic                    ren_stall,
    output logic [TAG_W-1:0]        ren_tag,
    output logic [2:0]              src_busy,
    output logic [2:0]              src_ready,
    output logic [3*TAG_W-1:0]      src_tag,
    output logic [FLAG_W-1:0]       src_flags,
    input  logic                    wb_valid,
    input  logic [TAG_W-1:0]        wb_tag,
    input  logic [FLAG_W-1:0]       wb_flags,
    input  logic                    cmt_valid,
    output logic                    cmt_done,
    input  logic                    flush,
    input  logic                    restore_valid,
    input  logic [FLAG_W-1:0]       restore_word,
    output logic [FLAG_W-1:0]       arch_flags
);
    localparam int unsigned CNT_W = $clog2(ROB_DEPTH + 1);

    logic [TAG_W-1:0]  head, tail;
    logic [CNT_W-1:0]  count;
    logic [ROB_DEPTH-1:0] done_vec;
    logic [FLAG_W-1:0] ent_flags [ROB_DEPTH];
    logic              head_occ, head_done, cfg_inflight;
    logic [NGRP-1:0]   head_wmask;
    logic              ren_fire, cmt_fire, restore_fire, rob_full, rob_empty;
    logic [FLAG_W-1:0] cmask;
    logic              map_v [NGRP];
    logic [TAG_W-1:0]  map_t [NGRP];
    logic [FLAG_W-1:0] grp_val [NGRP];
    logic [NGRP-1:0]   need;

    // Bit ownership mask of one group.
    function automatic logic [FLAG_W-1:0] gmask(input int unsigned g);
        logic [FLAG_W-1:0] m;
        for (int b = 0; b < FLAG_W; b++)
            m[b] = (grp_of_bit(b) == g);
        return m;
    endfunction

    assign rob_full  = (count == CNT_W'(ROB_DEPTH));
    assign rob_empty = (count == '0);
    assign ren_stall = flush || restore_valid || rob_full || cfg_inflight ||
                       (ren_wr[GRP_CFG] && !rob_empty);
    assign ren_fire     = ren_valid && !ren_stall;
    assign cmt_fire     = cmt_valid && !flush && head_occ && head_done;
    assign restore_fire = restore_valid && !flush && rob_empty;
    assign ren_tag      = tail;
    assign cmt_done     = cmt_fire;
    assign need         = ren_rd | (ren_wr & ren_part);

    // Expand the retiring entry's group mask to flag bits.
    always_comb begin
        for (int b = 0; b < FLAG_W; b++)
            cmask[b] = head_wmask[grp_of_bit(b)];
    end

    fr_rob_store #(
        .DEPTH(ROB_DEPTH), .FLAG_W(FLAG_W), .NGRP(NGRP), .CFG_G(GRP_CFG)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .alloc(ren_fire), .alloc_wmask(ren_wr),
        .wb_valid(wb_valid && !flush), .wb_tag(wb_tag), .wb_flags(wb_flags),
        .retire(cmt_fire), .flush(flush),
        .head(head), .tail(tail), .count(count),
        .done_vec(done_vec), .ent_flags(ent_flags),
        .head_occ(head_occ), .head_done(head_done), .head_wmask(head_wmask),
        .cfg_inflight(cfg_inflight)
    );

    fr_arch_flags #(.FLAG_W(FLAG_W)) u_arch (
        .clk(clk), .rst_n(rst_n),
        .commit(cmt_fire), .commit_mask(cmask),
        .commit_flags(ent_flags[head]),
        .restore(restore_fire), .restore_word(restore_word),
        .arch(arch_flags)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic hit_wb;

        fr_group_map #(.TAG_W(TAG_W)) u_map (
            .clk(clk), .rst_n(rst_n),
            .wr_group(ren_fire && ren_wr[g]), .alloc_tag(tail),
            .retire(cmt_fire), .retire_tag(head), .flush(flush),
            .map_valid(map_v[g]), .map_tag(map_t[g])
        );

        // Same-cycle writeback to this group's producer.
        assign hit_wb = wb_valid && (wb_tag == map_t[g]);

        // Source descriptor of this group for the renaming instruction.
        always_comb begin
            src_busy[g]                = need[g] && map_v[g];
            src_ready[g]               = !need[g] || !map_v[g] || done_vec[map_t[g]] || hit_wb;
            src_tag[g*TAG_W +: TAG_W]  = src_busy[g] ? map_t[g] : '0;
            if (!need[g])
                grp_val[g] = '0;
            else if (!map_v[g])
                grp_val[g] = arch_flags;
            else if (done_vec[map_t[g]])
                grp_val[g] = ent_flags[map_t[g]];
            else if (hit_wb)
                grp_val[g] = wb_flags;
            else
                grp_val[g] = '0;
        end
    end

    // Assemble the operand word from each group's own bits.
    always_comb begin
        src_flags = '0;
        for (int g = 0; g < NGRP; g++)
            src_flags = src_flags | (grp_val[g] & gmask(g));
    end

    // R9: a configuration writer only enters an empty buffer.
    a_r9_cfg_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_fire && ren_wr[GRP_CFG]) |-> rob_empty);
    // R9: nothing is renamed behind an in-flight configuration writer.
    a_r9_cfg_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_inflight |-> !ren_fire);
    // R5: a same-cycle writeback of a mapped producer wakes the reader.
    a_r5_bypass_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && need[GRP_CARRY] && map_v[GRP_CARRY] && wb_tag == map_t[GRP_CARRY])
        |-> src_ready[GRP_CARRY]);
endmodule

// File: tb/flag_rename_tracker_bench.sv
// Bench with a behavioural reference model compared every cycle.
module flag_rename_tracker_bench;
    localparam int D   = 16;
    localparam int TW  = 4;
    localparam int FW  = 8;
    localparam int NCYC = 4000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ren_valid = 0;
    logic [2:0]    ren_rd = 0, ren_wr = 0, ren_part = 0;
    logic          ren_stall;
    logic [TW-1:0] ren_tag;
    logic [2:0]    src_busy, src_ready;
    logic [3*TW-1:0] src_tag;
    logic [FW-1:0] src_flags;
    logic          wb_valid = 0;
    logic [TW-1:0] wb_tag = 0;
    logic [FW-1:0] wb_flags = 0;
    logic          cmt_valid = 0;
    logic          cmt_done;
    logic          flush = 0;
    logic          restore_valid = 0;
    logic [FW-1:0] restore_word = 0;
    logic [FW-1:0] arch_flags;

    int checks = 0;
    int fails  = 0;

    // Reference state.
    bit          m_occ [D];
    bit          m_dn  [D];
    logic [2:0]  m_wm  [D];
    logic [FW-1:0] m_fv [D];
    int          m_head = 0, m_tail = 0, m_cnt = 0;
    logic [FW-1:0] m_arch = 0;
    bit          m_mv [3];
    int          m_mt [3];

    always #2 clk = ~clk;

    flag_rename_tracker u_flag_rename_tracker (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_rd(ren_rd), .ren_wr(ren_wr), .ren_part(ren_part),
        .ren_stall(ren_stall), .ren_tag(ren_tag),
        .src_busy(src_busy), .src_ready(src_ready), .src_tag(src_tag), .src_flags(src_flags),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_flags(wb_flags),
        .cmt_valid(cmt_valid), .cmt_done(cmt_done), .flush(flush),
        .restore_valid(restore_valid), .restore_word(restore_word),
        .arch_flags(arch_flags)
    );

    function automatic int gb(input int b);
        return (b == 0) ? 0 : (b <= 3) ? 1 : 2;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    function automatic bit cfg_live();
        for (int i = 0; i < D; i++)
            if (m_occ[i] && m_wm[i][2]) return 1;
        return 0;
    endfunction

    function automatic bit exp_stall();
        return flush || restore_valid || (m_cnt == D) || cfg_live() ||
               (ren_wr[2] && m_cnt != 0);
    endfunction

    // Stimulus: a scripted chain first, then a random mix.
    task automatic gen(input int k);
        int q[$];
        ren_valid = 0; ren_rd = 0; ren_wr = 0; ren_part = 0;
        wb_valid = 0; wb_tag = 0; wb_flags = 0; cmt_valid = 0;
        flush = 0; restore_valid = 0; restore_word = 0;
        case (k)
            1: begin ren_valid = 1; ren_wr = 3'b011; end
            2: begin ren_valid = 1; ren_rd = 3'b001; end
            3: begin ren_valid = 1; ren_wr = 3'b001; end
            4: begin ren_valid = 1; ren_rd = 3'b011;
                     wb_valid = 1; wb_tag = 0; wb_flags = 8'h0E; end
            5: begin ren_valid = 1; ren_wr = 3'b010; ren_part = 3'b010; end
            6: begin ren_valid = 1; ren_wr = 3'b100; cmt_valid = 1; end
            7: begin restore_valid = 1; restore_word = 8'hA5; end
            default: if (k > 7) begin
                ren_valid = ($urandom % 10) < 6;
                ren_rd    = 3'($urandom);
                ren_wr    = {($urandom % 20) == 0, 2'($urandom)};
                ren_part  = 3'($urandom);
                for (int i = 0; i < D; i++)
                    if (m_occ[i] && !m_dn[i]) q.push_back(i);
                if (($urandom % 20) == 0) begin
                    wb_valid = 1; wb_tag = TW'($urandom);
                end else if (q.size() > 0 && ($urandom % 10) < 7) begin
                    wb_valid = 1; wb_tag = TW'(q[$urandom % q.size()]);
                end
                wb_flags      = FW'($urandom);
                cmt_valid     = ($urandom % 10) < 6;
                flush         = ($urandom % 50) == 0;
                restore_valid = ($urandom % 40) == 0;
                restore_word  = FW'($urandom);
            end
        endcase
    endtask

    // Compare every output against the model's prediction.
    task automatic compare();
        logic [2:0] need, e_busy, e_rdy;
        logic [3*TW-1:0] e_tag;
        logic [FW-1:0] e_val;
        need = ren_rd | (ren_wr & ren_part);
        e_tag = 0; e_val = 0;
        for (int g = 0; g < 3; g++) begin
            e_busy[g] = need[g] && m_mv[g];
            e_rdy[g]  = !need[g] || !m_mv[g] || m_dn[m_mt[g]] ||
                        (wb_valid && int'(wb_tag) == m_mt[g]);
            if (e_busy[g]) e_tag[g*TW +: TW] = TW'(m_mt[g]);
        end
        for (int b = 0; b < FW; b++) begin
            int g = gb(b);
            if (need[g]) begin
                if (!m_mv[g]) e_val[b] = m_arch[b];
                else if (m_dn[m_mt[g]]) e_val[b] = m_fv[m_mt[g]][b];
                else if (wb_valid && int'(wb_tag) == m_mt[g]) e_val[b] = wb_flags[b];
            end
        end
        chk("R2,R9,R11 ren_stall", 32'(ren_stall), 32'(exp_stall()));
        chk("R2 ren_tag", 32'(ren_tag), 32'(m_tail));
        chk("R3,R4,R8,R10 src_busy", 32'(src_busy), 32'(e_busy));
        chk("R3,R4 src_tag", 32'(src_tag), 32'(e_tag));
        chk("R5 src_ready", 32'(src_ready), 32'(e_rdy));
        chk("R6 src_flags", 32'(src_flags), 32'(e_val));
        chk("R7 cmt_done", 32'(cmt_done),
            32'(cmt_valid && !flush && m_occ[m_head] && m_dn[m_head]));
        chk("R7,R10,R11 arch_flags", 32'(arch_flags), 32'(m_arch));
    endtask

    // Advance the model by one clock edge with the held inputs.
    task automatic step();
        bit rf, cf, sf;
        if (flush) begin
            for (int i = 0; i < D; i++) begin m_occ[i] = 0; m_dn[i] = 0; end
            for (int g = 0; g < 3; g++) m_mv[g] = 0;
            m_tail = m_head; m_cnt = 0;
            return;
        end
        rf = ren_valid && !exp_stall();
        cf = cmt_valid && m_occ[m_head] && m_dn[m_head];
        sf = restore_valid && m_cnt == 0;
        if (wb_valid && m_occ[wb_tag] && !m_dn[wb_tag]) begin
            m_dn[wb_tag] = 1; m_fv[wb_tag] = wb_flags;
        end
        if (cf) begin
            for (int b = 0; b < FW; b++)
                if (m_wm[m_head][gb(b)]) m_arch[b] = m_fv[m_head][b];
            m_occ[m_head] = 0; m_dn[m_head] = 0;
            for (int g = 0; g < 3; g++)
                if (m_mv[g] && m_mt[g] == m_head && !(rf && ren_wr[g])) m_mv[g] = 0;
            m_head = (m_head + 1) % D;
        end
        if (rf) begin
            m_occ[m_tail] = 1; m_dn[m_tail] = 0; m_wm[m_tail] = ren_wr;
            for (int g = 0; g < 3; g++)
                if (ren_wr[g]) begin m_mv[g] = 1; m_mt[g] = m_tail; end
            m_tail = (m_tail + 1) % D;
        end
        if (sf) m_arch = restore_word;
        m_cnt = m_cnt + int'(rf) - int'(cf);
    endtask

    initial begin
        for (int i = 0; i < D; i++) begin m_occ[i] = 0; m_dn[i] = 0; m_wm[i] = 0; m_fv[i] = 0; end
        for (int g = 0; g < 3; g++) begin m_mv[g] = 0; m_mt[g] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state with all inputs low.
        chk("R1 ren_stall", 32'(ren_stall), 0);
        chk("R1 ren_tag", 32'(ren_tag), 0);
        chk("R1 arch_flags", 32'(arch_flags), 0);
        chk("R1 src_ready", 32'(src_ready), 32'h7);
        for (int k = 1; k <= NCYC; k++) begin
            @(negedge clk);
            gen(k);
            #1;
            compare();
            @(posedge clk);
            step();
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule